// File: doc/BRIEF.md
# T1 All-Ones Alarm Detector

This block decides whether a received T1 stream carries the all-ones alarm (AIS). It counts the data bits, qualified by a bit-valid strobe, into fixed observation windows of 250 microseconds. At 1.544 Mbit/s such a window is 386 valid bits. While the framer reports that synchronization is lost, the block counts the zero bits in each window. At the end of each window it raises the alarm if fewer than three zeros arrived and clears it if three or more arrived.

The alarm depends on loss of synchronization. As soon as the framer reports sync again, the flag drops, and the window and zero counters are held at their start. As a result, the first window after a loss of sync begins with the first valid bit that follows the loss. Between window ends the flag keeps its value. The output is meant to drive bit 0 of a status word that is assembled elsewhere.

Top module: `ais_detector`

## Requirements
- R1: An active-high synchronous reset clears the alarm flag and restarts the window and the zero count. After the reset, a full window of valid bits is needed before the flag can rise.
- R2: The flag is 0 in the cycle after any clock edge at which sync_lost is 0, whatever the data.
- R3: With sync_lost held at 1, if a window of WIN_BITS valid bits (default 386) contains 0, 1 or 2 zero bits, the flag is 1 from the cycle after the last bit of that window.
- R4: With sync_lost held at 1, if a window contains three or more zero bits, the flag is 0 from the cycle after the last bit of that window.
- R5: Cycles with bit_valid at 0 advance neither the window nor the zero count. The rx_bit value in those cycles has no effect.
- R6: While sync_lost is 1, the flag changes only at the clock edge that takes the last valid bit of a window.
- R7: Every window starts with an empty zero count. Zeros counted in one window, however many, never carry into the next.
- R8: After sync_lost rises, the first window consists of the first WIN_BITS valid bits that arrive while sync_lost stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate bit clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | rx_bit carries a received bit in this cycle |
| rx_bit | input | 1 | Received data bit |
| sync_lost | input | 1 | Framer reports loss of synchronization (1 = lost) |
| ais | output | 1 | All-ones alarm flag, status bit 0 |

## Verification
The bench goes after the zero-count threshold at exactly two and exactly three zeros. If the comparison were off by one, the flag would be set or cleared one zero too late. It places a zero on the very last bit of a window and inserts invalid cycles carrying a zero just before the window ends. A design that counted invalid cycles, or that ignored the final bit, would decide on the wrong window. Another case is a window with hundreds of zeros followed by a window with two zeros; a count that wrapped or carried over would miss the set. The bench also drops sync in the middle of a window and then regains sync. This exposes both a flag that lingers after sync returns and a window that does not restart when sync is lost again.

// File: rtl/ais_detector.sv
module ais_detector #(
  parameter int WIN_BITS = 386
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic rx_bit,
  input  logic sync_lost,
  output logic ais
);
  localparam int CW = $clog2(WIN_BITS);

  logic [CW-1:0] win_cnt;
  logic [1:0]    zcnt;
  logic [1:0]    znext;
  logic          win_end;

  assign win_end = bit_valid && (win_cnt == CW'(WIN_BITS - 1));
  assign znext   = (!rx_bit && zcnt != 2'd3) ? zcnt + 2'd1 : zcnt;

  always_ff @(posedge clk) begin
    if (rst || !sync_lost) begin
      win_cnt <= '0;
      zcnt    <= '0;
      ais     <= 1'b0;
    end else if (bit_valid) begin
      if (win_end) begin
        ais     <= (znext != 2'd3);
        win_cnt <= '0;
        zcnt    <= '0;
      end else begin
        win_cnt <= win_cnt + 1'b1;
        zcnt    <= znext;
      end
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!ais && win_cnt == '0 && zcnt == 2'd0));

  a_r2_needs_loss: assert property (@(posedge clk) disable iff (rst)
    !sync_lost |=> !ais);

  a_r3_set_few_zeros: assert property (@(posedge clk) disable iff (rst)
    (sync_lost && win_end && znext != 2'd3) |=> ais);

  a_r4_clear_many_zeros: assert property (@(posedge clk) disable iff (rst)
    (sync_lost && win_end && znext == 2'd3) |=> !ais);

  a_r5_idle_no_advance: assert property (@(posedge clk) disable iff (rst)
    (sync_lost && !bit_valid) |=> ($stable(win_cnt) && $stable(zcnt)));

  a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
    (sync_lost && !win_end) |=> $stable(ais));

  a_r7_window_restart: assert property (@(posedge clk) disable iff (rst)
    win_end |=> (win_cnt == '0 && zcnt == 2'd0));
endmodule

// File: tb/tb_ais_detector.sv
module tb_ais_detector;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 386;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic rx_bit = 1'b1;
  logic sync_lost = 1'b0;
  logic ais;

  int total = 0;
  int bad = 0;
  int m_win = 0;
  int m_zeros = 0;
  logic m_ais = 1'b0;
  bit done = 1'b0;

  ais_detector #(.WIN_BITS(WIN)) dut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .rx_bit(rx_bit),
    .sync_lost(sync_lost), .ais(ais)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic window_verdict(int zeros);
    return zeros < 3;
  endfunction

  task automatic check(string tag, logic exp);
    total++;
    if (ais !== exp) begin
      bad++;
      $display("FAIL %s: ais=%b expected=%b at %0t", tag, ais, exp, $time);
    end
  endtask

  task automatic step(logic v, logic b, logic s, logic r, string tag);
    bit_valid = v; rx_bit = b; sync_lost = s; rst = r;
    @(posedge clk);
    if (r || !s) begin
      m_win = 0; m_zeros = 0; m_ais = 1'b0;
    end else if (v) begin
      m_win++;
      if (!b) m_zeros++;
      if (m_win == WIN) begin
        m_ais = window_verdict(m_zeros);
        m_win = 0; m_zeros = 0;
      end
    end
    @(negedge clk);
    check(tag, m_ais);
  endtask

  task automatic window(int nz, int gaps, string tag);
    for (int i = 0; i < WIN; i++) begin
      logic z;
      z = (i >= WIN - nz);
      if (gaps > 0 && (i % 50 == 7)) step(1'b0, 1'b0, 1'b1, 1'b0, "R5");
      step(1'b1, !z, 1'b1, 1'b0, (i == WIN - 1) ? tag : "R6");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: ais=%b expected=done", ais);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    step(1'b0, 1'b1, 1'b1, 1'b1, "R1");
    step(1'b0, 1'b1, 1'b1, 1'b1, "R1");

    for (int i = 0; i < WIN + 10; i++) step(1'b1, 1'b1, 1'b0, 1'b0, "R2");
    window(0, 0, "R3");
    check("R3 all ones set", 1'b1);
    window(2, 0, "R3");
    check("R3 two zeros keep", 1'b1);
    window(3, 0, "R4");
    check("R4 three zeros clear", 1'b0);
    window(1, 1, "R5");
    check("R5 gaps ignored", 1'b1);
    for (int i = 0; i < WIN; i++) step(1'b1, (i % 2 == 0), 1'b1, 1'b0, "R6");
    check("R4 many zeros", 1'b0);
    window(2, 0, "R7");
    check("R7 no carry", 1'b1);

    for (int i = 0; i < 100; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R6");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R2");
    check("R2 sync regained", 1'b0);
    for (int i = 0; i < 200; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R2");
    for (int i = 0; i < WIN - 1; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R8");
    check("R8 one short", 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0, "R8");
    check("R8 first window", 1'b1);

    for (int i = 0; i < 200; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b1, "R1");
    check("R1 reset clears", 1'b0);
    for (int i = 0; i < WIN - 1; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R1");
    check("R1 window restarted", 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0, "R3");

    for (int i = 0; i < WIN - 1; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R6");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R5");
    check("R5 invalid zeros", 1'b1);
    step(1'b1, 1'b0, 1'b1, 1'b0, "R3");
    check("R3 last bit zero", 1'b1);

    begin
      logic s;
      s = 1'b1;
      for (int i = 0; i < 40000; i++) begin
        if ($urandom_range(0, 2999) == 0) s = ~s;
        step($urandom_range(0, 7) != 0, $urandom_range(0, 299) != 0, s,
             $urandom_range(0, 19999) == 0, "R3/R4 random");
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule